// File: doc/BRIEF.md
# Reference Ratio Trim Search Engine

This block is a self-test sequencer for wafer-sort calibration of a resistive memory array. The array is split into local reference-trim units. Each unit has one merged sensing reference built from 36 reference cells. A trim code sets how many of those cells are in the low-resistance state; the rest are in the high-resistance state. For every unit, the engine tries every code in turn. For each code it reads back all of the unit's data bits, compares them with an internally generated expected pattern, and counts the mismatches. It keeps the code that produced the fewest failures.

A single `start` pulse launches the whole search over all units. Reads go out one at a time over a request/acknowledge port, and the trim code under test is presented beside them. When the last unit has been settled, a one-cycle `done` pulse marks that every unit's winning code and its failure count are ready on the result outputs. Those outputs then hold until the same unit is settled again in a later search.

Top module: `ref_trim_search`

## Requirements
- R1: For each unit in ascending order, the trim code on `trimCode` steps from 0 to `REF_CELLS` (36 by default). For each code, every data bit of the unit (`GROUPS*REF_CELLS` bits, 576 by default) is read once, in ascending bit index. One search therefore makes `NUM_UNITS*(REF_CELLS+1)*GROUPS*REF_CELLS` reads.
- R2: Once `rdReq` is raised, it stays high and `rdUnit`, `rdBit` and `trimCode` stay stable until a cycle in which `rdAck` is high. That cycle completes exactly one read and samples `rdData`.
- R3: The expected value of a bit is `rdBit[0] XOR rdUnit[0]`. This is a checkerboard on even units and its inverse on odd units. Any other read value counts as one failure.
- R4: The failure count of a code saturates at `2**CNT_W-1` (1023 by default) and never wraps.
- R5: The result for a unit is the code with the lowest failure count.
- R6: When failure counts are equal, the code whose distance from the 1:1 default (`REF_CELLS/2`, i.e. 18) is smaller wins. Between codes at equal distance, the lower code wins.
- R7: Each unit has a result code (`CODE_W` bits at slice `u*CODE_W` of `resultCode`) and a failure count (`CNT_W` bits at slice `u*CNT_W` of `resultFails`). After reset these are code 18 and 0 failures. A unit's result changes only when that unit finishes its sweep; until then it holds its previous value, even during a new search.
- R8: `done` is high for exactly one cycle, in the cycle after the last unit's result is written. `rdReq` is low while `done` is high.
- R9: `start` is accepted only when the engine is idle. A pulse during a search does not restart it or add reads.
- R10: After reset and after every search, `rdReq` and `done` are low and `trimCode` is at the default 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a full search while idle |
| done | output | 1 | One-cycle pulse when all units are settled |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdUnit | output | UNIT_W | Trim unit being read |
| rdBit | output | BIT_W | Data bit index within the unit |
| rdAck | input | 1 | Read completion; `rdData` valid in this cycle |
| rdData | input | 1 | Bit value read from the array |
| trimCode | output | CODE_W | Number of low-resistance reference cells applied |
| resultCode | output | NUM_UNITS*CODE_W | Winning code per unit |
| resultFails | output | NUM_UNITS*CNT_W | Failure count of the winning code per unit |

## Verification
A corrupted bit, code or unit counter shows up at the read port on the very next request, as an out-of-order address or a code outside 0..36. A wrong failure counter or best-code register stays hidden until the unit's sweep ends. At that point it shows as a wrong winning code or count on the result outputs, which is roughly one unit-sweep later. The stimulus uses failure profiles with single minima, flat plateaus, symmetric twin minima, minima at both ends of the code range, and counts above the saturation limit. Because the pattern is inverted on odd units, a wrong expected-data polarity turns into a large failure count on half the units.

// File: rtl/rtse_pkg.sv
package rtse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_STORE,
    ST_FIN
  } state_e;

  typedef struct packed {
    logic bitClr;
    logic bitInc;
    logic codeClr;
    logic codeInc;
    logic codeDef;
    logic unitClr;
    logic unitInc;
    logic clrCount;
    logic countEn;
    logic evalEn;
    logic storeEn;
  } ctl_t;

endpackage

// File: rtl/rtse_ctrl.sv
module rtse_ctrl
  import rtse_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic rdAck,
  input  logic lastBit,
  input  logic lastCode,
  input  logic lastUnit,
  output ctl_t ctl,
  output logic rdReq,
  output logic done
);

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    rdReq     = 1'b0;
    done      = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.bitClr   = 1'b1;
          ctl.codeClr  = 1'b1;
          ctl.unitClr  = 1'b1;
          ctl.clrCount = 1'b1;
          stateNext    = ST_READ;
        end
      end
      ST_READ: begin
        rdReq = 1'b1;
        if (rdAck) begin
          ctl.countEn = 1'b1;
          if (lastBit) stateNext = ST_EVAL;
          else         ctl.bitInc = 1'b1;
        end
      end
      ST_EVAL: begin
        ctl.evalEn = 1'b1;
        if (lastCode) stateNext = ST_STORE;
        else begin
          ctl.codeInc  = 1'b1;
          ctl.bitClr   = 1'b1;
          ctl.clrCount = 1'b1;
          stateNext    = ST_READ;
        end
      end
      ST_STORE: begin
        ctl.storeEn = 1'b1;
        if (lastUnit) stateNext = ST_FIN;
        else begin
          ctl.unitInc  = 1'b1;
          ctl.codeClr  = 1'b1;
          ctl.bitClr   = 1'b1;
          ctl.clrCount = 1'b1;
          stateNext    = ST_READ;
        end
      end
      ST_FIN: begin
        done        = 1'b1;
        ctl.codeDef = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rtse_datapath.sv
module rtse_datapath
  import rtse_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int REF_CELLS = 36,
  parameter int GROUPS    = 16,
  parameter int CNT_W     = 10,
  localparam int BITS     = GROUPS * REF_CELLS,
  localparam int BIT_W    = (BITS > 1) ? $clog2(BITS) : 1,
  localparam int CODE_W   = $clog2(REF_CELLS + 1),
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_t                        ctl,
  input  logic                        rdData,
  output logic [UNIT_W-1:0]           rdUnit,
  output logic [BIT_W-1:0]            rdBit,
  output logic [CODE_W-1:0]           trimCode,
  output logic                        lastBit,
  output logic                        lastCode,
  output logic                        lastUnit,
  output logic [NUM_UNITS*CODE_W-1:0] resultCode,
  output logic [NUM_UNITS*CNT_W-1:0]  resultFails
);

  localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'(REF_CELLS / 2);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [CNT_W-1:0]  failCnt, bestFails;
  logic [CODE_W-1:0] bestCode;
  logic              mismatch, candBetter;

  function automatic logic [CODE_W-1:0] distFromDef(input logic [CODE_W-1:0] c);
    return (c >= DEF_CODE) ? (c - DEF_CODE) : (DEF_CODE - c);
  endfunction

  assign lastBit  = (rdBit == BIT_W'(BITS - 1));
  assign lastCode = (trimCode == CODE_W'(REF_CELLS));
  assign lastUnit = (rdUnit == UNIT_W'(NUM_UNITS - 1));

  // checkerboard on even units, inverted checkerboard on odd units
  assign mismatch = rdData ^ (rdBit[0] ^ rdUnit[0]);

  assign candBetter = (trimCode == '0) || (failCnt < bestFails) ||
                      ((failCnt == bestFails) &&
                       (distFromDef(trimCode) < distFromDef(bestCode)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBit    <= '0;
      rdUnit   <= '0;
      trimCode <= DEF_CODE;
    end else begin
      if (ctl.bitClr)       rdBit <= '0;
      else if (ctl.bitInc)  rdBit <= rdBit + 1'b1;
      if (ctl.unitClr)      rdUnit <= '0;
      else if (ctl.unitInc) rdUnit <= rdUnit + 1'b1;
      if (ctl.codeClr)      trimCode <= '0;
      else if (ctl.codeInc) trimCode <= trimCode + 1'b1;
      else if (ctl.codeDef) trimCode <= DEF_CODE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt <= '0;
    end else if (ctl.clrCount) begin
      failCnt <= '0;
    end else if (ctl.countEn && mismatch && (failCnt != CNT_MAX)) begin
      failCnt <= failCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestCode  <= DEF_CODE;
      bestFails <= '0;
    end else if (ctl.evalEn && candBetter) begin
      bestCode  <= trimCode;
      bestFails <= failCnt;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_result
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultCode[u*CODE_W +: CODE_W] <= DEF_CODE;
        resultFails[u*CNT_W +: CNT_W]  <= '0;
      end else if (ctl.storeEn && (rdUnit == UNIT_W'(u))) begin
        resultCode[u*CODE_W +: CODE_W] <= bestCode;
        resultFails[u*CNT_W +: CNT_W]  <= bestFails;
      end
    end
  end

endmodule

// File: rtl/ref_trim_search.sv
module ref_trim_search
  import rtse_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int REF_CELLS = 36,
  parameter int GROUPS    = 16,
  parameter int CNT_W     = 10,
  localparam int BITS     = GROUPS * REF_CELLS,
  localparam int BIT_W    = (BITS > 1) ? $clog2(BITS) : 1,
  localparam int CODE_W   = $clog2(REF_CELLS + 1),
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  output logic                        done,
  output logic                        rdReq,
  output logic [UNIT_W-1:0]           rdUnit,
  output logic [BIT_W-1:0]            rdBit,
  input  logic                        rdAck,
  input  logic                        rdData,
  output logic [CODE_W-1:0]           trimCode,
  output logic [NUM_UNITS*CODE_W-1:0] resultCode,
  output logic [NUM_UNITS*CNT_W-1:0]  resultFails
);

  ctl_t ctl;
  logic lastBit, lastCode, lastUnit;

  rtse_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rdAck    (rdAck),
    .lastBit  (lastBit),
    .lastCode (lastCode),
    .lastUnit (lastUnit),
    .ctl      (ctl),
    .rdReq    (rdReq),
    .done     (done)
  );

  rtse_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .REF_CELLS (REF_CELLS),
    .GROUPS    (GROUPS),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .rdData      (rdData),
    .rdUnit      (rdUnit),
    .rdBit       (rdBit),
    .trimCode    (trimCode),
    .lastBit     (lastBit),
    .lastCode    (lastCode),
    .lastUnit    (lastUnit),
    .resultCode  (resultCode),
    .resultFails (resultFails)
  );

endmodule

// File: rtl/rtse_checker.sv
module rtse_checker #(
  parameter int NUM_UNITS = 4,
  parameter int REF_CELLS = 36,
  parameter int GROUPS    = 16,
  localparam int BITS     = GROUPS * REF_CELLS,
  localparam int BIT_W    = (BITS > 1) ? $clog2(BITS) : 1,
  localparam int CODE_W   = $clog2(REF_CELLS + 1),
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              rdReq,
  input logic              rdAck,
  input logic [UNIT_W-1:0] rdUnit,
  input logic [BIT_W-1:0]  rdBit,
  input logic [CODE_W-1:0] trimCode
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdBit) && $stable(rdUnit) && $stable(trimCode)));

  p_code_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    trimCode <= CODE_W'(REF_CELLS));

  p_bit_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && (rdBit != BIT_W'(BITS - 1))) |=>
    (rdReq && (rdBit == BIT_W'($past(rdBit) + 1'b1))));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rdReq);

  p_idle_default_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (trimCode == CODE_W'(REF_CELLS / 2)));

endmodule

bind ref_trim_search rtse_checker #(
  .NUM_UNITS (NUM_UNITS),
  .REF_CELLS (REF_CELLS),
  .GROUPS    (GROUPS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .done     (done),
  .rdReq    (rdReq),
  .rdAck    (rdAck),
  .rdUnit   (rdUnit),
  .rdBit    (rdBit),
  .trimCode (trimCode)
);

// File: tb/sim_ref_trim_search.sv
`timescale 1ns/1ps
module sim_ref_trim_search;

  localparam int NU = 2;
  localparam int RC = 36;
  localparam int GR = 1;
  localparam int CW = 5;
  localparam int NBITS = GR * RC;
  localparam int READS = NU * (RC + 1) * NBITS;
  localparam int SATV = (1 << CW) - 1;

  // per vector: u0 {c,d,s,b}, u1 {c,d,s,b}, u0 expCode, u0 expFails, u1 expCode, u1 expFails
  localparam int VEC [0:4][0:11] = '{
    '{10, 0, 2, 0,  25, 0, 1, 3,   10, 0,  25, 3},
    '{ 0, 0, 0, 5,   0, 0, 0, 36,  18, 5,  18, 31},
    '{18, 4, 3, 2,   0, 0, 1, 0,   14, 2,   0, 0},
    '{36, 0, 1, 0,  18, 3, 2, 1,   36, 0,  15, 1},
    '{ 5, 0, 1, 30, 20, 0, 10, 0,   5, 30, 20, 0}
  };
  localparam string TAG [0:4] = '{"R5 R3", "R6 R4", "R6", "R1 R6", "R4 R5"};

  logic clk = 0, rstN = 0, start = 0, rdAck = 0, rdData = 0;
  logic done, rdReq;
  logic [0:0] rdUnit;
  logic [5:0] rdBit, trimCode;
  logic [NU*6-1:0]  resultCode;
  logic [NU*CW-1:0] resultFails;

  int nChecks = 0, nFails = 0;
  int pc[0:1], pd[0:1], ps[0:1], pb[0:1];
  int reads = 0, orderErr = 0, doneCnt = 0;
  int expU = 0, expC = 0, expB = 0;

  always #2.5 clk = ~clk;

  ref_trim_search #(.NUM_UNITS(NU), .REF_CELLS(RC), .GROUPS(GR), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .rdReq(rdReq),
    .rdUnit(rdUnit), .rdBit(rdBit), .rdAck(rdAck), .rdData(rdData),
    .trimCode(trimCode), .resultCode(resultCode), .resultFails(resultFails));

  function automatic int failLevel(int u, int code);
    int a, f;
    a = (code > pc[u]) ? code - pc[u] : pc[u] - code;
    a = (a > pd[u]) ? a - pd[u] : pd[u] - a;
    f = pb[u] + ps[u] * a;
    return (f > NBITS) ? NBITS : f;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // array responder: acknowledges one cycle after each request
  initial begin
    forever begin
      @(negedge clk);
      if (rdAck) rdAck = 0;
      else if (rdReq) begin
        if (int'(rdUnit) != expU || int'(trimCode) != expC || int'(rdBit) != expB) orderErr++;
        expB++;
        if (expB == NBITS) begin
          expB = 0; expC++;
          if (expC == RC + 1) begin expC = 0; expU++; end
        end
        reads++;
        rdData = (rdBit[0] ^ rdUnit[0]) ^ (int'(rdBit) < failLevel(int'(rdUnit), int'(trimCode)));
        rdAck = 1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) doneCnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  task automatic loadVec(int i);
    for (int u = 0; u < 2; u++) begin
      pc[u] = VEC[i][u*4]; pd[u] = VEC[i][u*4+1];
      ps[u] = VEC[i][u*4+2]; pb[u] = VEC[i][u*4+3];
    end
    reads = 0; orderErr = 0; doneCnt = 0; expU = 0; expC = 0; expB = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkResults(int i, string tag);
    for (int u = 0; u < 2; u++) begin
      check(tag, int'(resultCode[u*6 +: 6]), VEC[i][8 + u*2]);
      check(tag, int'(resultFails[u*CW +: CW]), VEC[i][9 + u*2]);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    check("R10 rdReq", int'(rdReq), 0);
    check("R10 done", int'(done), 0);
    check("R10 trimCode", int'(trimCode), 18);
    for (int u = 0; u < 2; u++) begin
      check("R7 reset code", int'(resultCode[u*6 +: 6]), 18);
      check("R7 reset fails", int'(resultFails[u*CW +: CW]), 0);
    end

    // table walk
    for (int i = 0; i < 5; i++) begin
      loadVec(i);
      pulseStart();
      waitDone();
      checkResults(i, TAG[i]);
      check("R1 read count", reads, READS);
      check("R2 read order", orderErr, 0);
      @(negedge clk);
      check("R8 done width", int'(done), 0);
      check("R10 trimCode idle", int'(trimCode), 18);
      check("R10 rdReq idle", int'(rdReq), 0);
      check("R8 done count", doneCnt, 1);
    end

    // saturation bound on unit 1 of vector 1 already at SATV
    check("R4 saturation value", VEC[1][11], SATV);

    // hold across a new search and ignored start mid-run
    loadVec(0);
    pulseStart();
    repeat (300) @(negedge clk);
    checkResults(4, "R7 hold during search");
    pulseStart();
    waitDone();
    check("R9 reads after extra start", reads, READS);
    check("R9 order after extra start", orderErr, 0);
    checkResults(0, "R9 results");
    repeat (100) @(negedge clk);
    check("R9 single done", doneCnt, 1);
    checkResults(0, "R7 hold after done");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule